// File: doc/BRIEF.md
# Oscillator Bias Trim Search Controller

This block chooses the bias-trim code for a crystal oscillator by reading two status bits from an amplitude comparator. One bit is `hi`, which is set when the trim is too high. The other is `lo`, which is clear when the trim is too low. The code starts at zero. Each trial ORs in the next bit weight, from the most significant down. After every trial the block holds the code for a fixed settle interval and then reads the comparator. It keeps the weight only while `lo` stays clear, so the search lands on the largest code that is still too low. After the search, a fix-up step adds one if `lo` is still clear. A safety margin is then added, saturating at the top code, and `done_o` pulses for one cycle.

Later, system software can request single-step maintenance checks. Each check nudges the code down when `hi` is set. It raises the code by one plus the margin when `lo` is clear. The result is never allowed to fall below the margin.

States: `ST_IDLE` (waiting), `ST_LOAD` (apply a trial weight and arm the settle timer), `ST_WAIT` (settle), `ST_JUDGE` (sample `lo` and drop the weight if it is set), `ST_FIX` (final +1 when `lo` is clear), `ST_OFFS` (add the margin, pulse done).

Transitions:
- IDLE→LOAD on `start_i`.
- IDLE→IDLE on `check_i`, which performs one maintenance step.
- LOAD→WAIT always.
- WAIT→JUDGE when the timer expires.
- JUDGE→LOAD while lower weights remain.
- JUDGE→FIX after the least significant weight.
- FIX→OFFS always.
- OFFS→IDLE always.

Top module: `bias_trim_ctrl`

## Requirements
- R1: After reset `trim_o` is 0, `done_o` is 0 and the block is idle.
- R2: `start_i` in idle clears the trim to 0 and begins the search. `start_i` takes priority over `check_i` in the same cycle.
- R3: Each trial code is held unchanged for exactly SETTLE_CYC cycles after it is applied, and only then is `lo` sampled.
- R4: The trials go from weight 2^(TRIM_W-1) down to weight 1. A weight is removed again if `lo` is 1 when sampled and kept if `lo` is 0.
- R5: After the last trial, if `lo` is 0 the trim rises by one, saturating at 2^TRIM_W-1.
- R6: The block then adds OFFSET (2) to the trim, saturating at 2^TRIM_W-1. `done_o` is high for exactly the one cycle after that update and low at all other times.
- R7: A maintenance check in idle with `hi` = 1 lowers the trim by one.
- R8: A maintenance check with `lo` = 0 raises the trim by one and then by OFFSET, saturating at 2^TRIM_W-1. If `hi` and `lo` = 0 occur together, the decrement is applied first.
- R9: After any maintenance check the trim is at least OFFSET.
- R10: `check_i` and `start_i` have no effect while a search is running.
- R11: In idle, with no request, changes on `hi` and `lo` leave the trim unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a full search |
| check_i | input | 1 | Request one maintenance step |
| comp_hi_i | input | 1 | Comparator: trim too high when 1 |
| comp_lo_i | input | 1 | Comparator: trim too low when 0 |
| trim_o | output | TRIM_W | Current bias-trim code |
| done_o | output | 1 | One-cycle pulse when a search completes |

## Verification
The assertions check several properties on every cycle:
- the trim holds still during settling;
- `done_o` never lasts more than one cycle;
- the trim stays at or above the margin after a check or after the margin step;
- the trim does not move in idle without a request;
- a start clears the trim.

Other behaviours need the bench's scenarios, which use a threshold comparator model:
- the exact code the search converges to;
- the fix-up increment;
- saturation at the top code;
- the stepping of maintenance checks down to the floor;
- requests being ignored during a search.

// File: rtl/bias_trim_pkg.sv
package bias_trim_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_JUDGE,
        ST_FIX,
        ST_OFFS
    } trim_state_e;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CYC = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= CW'(CYC - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/trim_math.sv
module trim_math #(
    parameter int W      = 4,
    parameter int OFFSET = 2
) (
    input  logic [W-1:0] trim_i,
    input  logic         hi_i,
    input  logic         lo_i,
    output logic [W-1:0] plus_off_o,
    output logic [W-1:0] chk_next_o
);
    localparam int MAXV = (1 << W) - 1;

    int a;
    int c;

    always_comb begin
        a = int'(trim_i) + OFFSET;
        if (a > MAXV)
            a = MAXV;
        plus_off_o = W'(a);

        c = int'(trim_i);
        if (hi_i)
            c = c - 1;
        if (!lo_i) begin
            c = c + 1 + OFFSET;
            if (c > MAXV)
                c = MAXV;
        end
        if (c < OFFSET)
            c = OFFSET;
        chk_next_o = W'(c);
    end
endmodule

// File: rtl/bias_trim_ctrl.sv
module bias_trim_ctrl
    import bias_trim_pkg::*;
#(
    parameter int TRIM_W     = 4,
    parameter int SETTLE_CYC = 24000,
    parameter int OFFSET     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              check_i,
    input  logic              comp_hi_i,
    input  logic              comp_lo_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic              done_o
);
    localparam logic [TRIM_W-1:0] MAXC = {TRIM_W{1'b1}};
    localparam logic [TRIM_W-1:0] MSBW = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [TRIM_W-1:0] FLOOR = TRIM_W'(OFFSET);

    trim_state_e       st_q, st_d;
    logic [TRIM_W-1:0] trim_q;
    logic [TRIM_W-1:0] wt_q;
    logic              done_q;
    logic              tmr_load;
    logic              tmr_exp;
    logic [TRIM_W-1:0] plus_off;
    logic [TRIM_W-1:0] chk_next;

    settle_timer #(.CYC(SETTLE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_exp)
    );

    trim_math #(.W(TRIM_W), .OFFSET(OFFSET)) u_math (
        .trim_i     (trim_q),
        .hi_i       (comp_hi_i),
        .lo_i       (comp_lo_i),
        .plus_off_o (plus_off),
        .chk_next_o (chk_next)
    );

    assign tmr_load = (st_q == ST_LOAD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start_i) st_d = ST_LOAD;
            ST_LOAD:  st_d = ST_WAIT;
            ST_WAIT:  if (tmr_exp) st_d = ST_JUDGE;
            ST_JUDGE: st_d = (wt_q == TRIM_W'(1)) ? ST_FIX : ST_LOAD;
            ST_FIX:   st_d = ST_OFFS;
            ST_OFFS:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_q <= '0;
            wt_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        trim_q <= '0;
                        wt_q   <= MSBW;
                    end else if (check_i) begin
                        trim_q <= chk_next;
                    end
                end
                ST_LOAD:  trim_q <= trim_q | wt_q;
                ST_WAIT:  ;
                ST_JUDGE: begin
                    if (comp_lo_i)
                        trim_q <= trim_q & ~wt_q;
                    wt_q <= wt_q >> 1;
                end
                ST_FIX: begin
                    if (!comp_lo_i && trim_q != MAXC)
                        trim_q <= trim_q + 1'b1;
                end
                ST_OFFS: begin
                    trim_q <= plus_off;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign trim_o = trim_q;
    assign done_o = done_q;

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start_i) |=> (trim_q == '0));

    // R3
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |=> $stable(trim_q));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFFS) |=> (done_o && trim_q >= FLOOR));

    // R9
    check_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && check_i && !start_i) |=> (trim_q >= FLOOR));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !start_i && !check_i) |=> $stable(trim_q));
endmodule

// File: tb/bias_trim_ctrl_tb_top.sv
module bias_trim_ctrl_tb_top;
    localparam int W   = 4;
    localparam int SC  = 6;
    localparam int OFS = 2;
    localparam int MX  = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         check_i = 1'b0;
    logic         comp_hi_i = 1'b0;
    logic         comp_lo_i = 1'b0;
    logic [W-1:0] trim_o;
    logic         done_o;

    int t_lo = 100;
    int t_hi = 100;
    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bias_trim_ctrl #(.TRIM_W(W), .SETTLE_CYC(SC), .OFFSET(OFS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .check_i   (check_i),
        .comp_hi_i (comp_hi_i),
        .comp_lo_i (comp_lo_i),
        .trim_o    (trim_o),
        .done_o    (done_o)
    );

    // threshold comparator model
    always @(negedge clk) begin
        comp_lo_i <= (int'(trim_o) >= t_lo);
        comp_hi_i <= (int'(trim_o) > t_hi);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int    m_ph = 0, m_trim = 0, m_w = 0, m_cnt = 0, m_done = 0;
    string m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_trim = 0; m_w = 0; m_cnt = 0; m_done = 0; m_tag = "R1";
        end else begin
            m_done = 0;
            case (m_ph)
                0: begin
                    if (start_i) begin
                        m_trim = 0; m_w = 1 << (W - 1); m_ph = 1; m_tag = "R2";
                    end else if (check_i) begin
                        if (comp_hi_i) m_trim = m_trim - 1;
                        if (!comp_lo_i) m_trim = m_trim + 1 + OFS;
                        if (m_trim > MX) m_trim = MX;
                        if (m_trim < OFS) m_trim = OFS;
                        m_tag = "R9";
                    end else m_tag = "R11";
                end
                1: begin m_trim = m_trim | m_w; m_cnt = SC; m_ph = 2; m_tag = "R4"; end
                2: begin m_cnt--; if (m_cnt == 0) m_ph = 3; m_tag = "R3"; end
                3: begin
                    if (comp_lo_i) m_trim = m_trim - m_w;
                    m_ph = (m_w == 1) ? 4 : 1;
                    m_w = m_w >> 1;
                    m_tag = "R4";
                end
                4: begin
                    if (!comp_lo_i && m_trim < MX) m_trim++;
                    m_ph = 5; m_tag = "R5";
                end
                default: begin
                    m_trim = (m_trim + OFS > MX) ? MX : m_trim + OFS;
                    m_done = 1; m_ph = 0; m_tag = "R6";
                end
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(trim_o) == m_trim, {m_tag, " trim"}, int'(trim_o), m_trim);
            chk(int'(done_o) == m_done, "R6 done", int'(done_o), m_done);
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic run_search(input int lo_thr, input int exp, input string tag,
                              input bit poke);
        t_lo = lo_thr; t_hi = 100;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            check_i = 1'b1; start_i = 1'b1;
            @(negedge clk); check_i = 1'b0; start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk(int'(trim_o) == exp, tag, int'(trim_o), exp);
        @(negedge clk);
    endtask

    task automatic do_check(input int lo_thr, input int hi_thr, input int exp,
                            input string tag);
        t_lo = lo_thr; t_hi = hi_thr;
        repeat (2) @(negedge clk);
        check_i = 1'b1;
        @(negedge clk); check_i = 1'b0;
        chk(int'(trim_o) == exp, tag, int'(trim_o), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(trim_o == '0, "R1 reset trim", int'(trim_o), 0);
        chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_search(5, 7, "R4 search thr5", 1'b0);
        run_search(0, 2, "R6 search thr0", 1'b0);
        run_search(16, 15, "R5 search saturate", 1'b0);
        run_search(9, 11, "R5 search thr9", 1'b0);
        run_search(5, 7, "R10 requests during search", 1'b1);

        // R11: comparator activity in idle
        for (int k = 0; k < 6; k++) begin
            t_lo = (k % 2) ? 0 : 16; t_hi = (k % 2) ? -1 : 100;
            @(negedge clk);
        end
        chk(int'(trim_o) == 7, "R11 idle hold", int'(trim_o), 7);

        // R7 / R9: step down to floor
        do_check(0, -1, 6, "R7 step down");
        do_check(0, -1, 5, "R7 step down");
        do_check(0, -1, 4, "R7 step down");
        do_check(0, -1, 3, "R7 step down");
        do_check(0, -1, 2, "R7 step down");
        do_check(0, -1, 2, "R9 floor");
        do_check(0, 100, 2, "R9 no change");
        // R8: step up with saturation
        do_check(16, 100, 5, "R8 step up");
        do_check(16, 100, 8, "R8 step up");
        do_check(16, 100, 11, "R8 step up");
        do_check(16, 100, 14, "R8 step up");
        do_check(16, 100, 15, "R8 saturate");
        do_check(16, -1, 15, "R8 both bits");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule